// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns a floating-point value held in a wide, unpacked form into a 32-bit IEEE-754 single-precision word. It sits at the end of an arithmetic pipeline. That pipeline delivers four things: a class code, a sign, an unbiased exponent, and a 64-bit significand with two extra low bits below it, together with a sticky bit that summarises anything already discarded upstream. The packer rounds the value to 24 significant bits using the rounding direction it is given, and it reports inexact, underflow and overflow.

Normal results are rounded and biased. Results too small for a normal exponent take a denormalising path. That path shifts the significand right, keeps the leading one inside the fraction, and may round back up into the smallest normal number. Results too large become either infinity or the largest finite number, depending on the rounding direction and the sign. NaN, infinity and zero bypass rounding altogether. The packed word and its flags are registered and appear one cycle after a valid input.

Top module: `fp_sgl_packer`

## Requirements
- R1: `out_valid` is high in the cycle after the clock edge that sampled `in_valid` high, and low after an edge that sampled it low. After reset, `out_valid`, `out_word` and all flags are zero.
- R2: The class codes are 0 zero, 1 number, 2 infinity, 3 NaN. For class 3 the result is: the sign, exponent field 255, fraction bit 22 forced to 1, and fraction bits 21..0 copied from `in_mant[63:42]`. No flag is raised.
- R3: Class 2 packs as the sign with exponent 255 and fraction 0. Class 0 packs as the sign with all other bits 0. Neither raises a flag, whatever the rounding inputs are.
- R4: `in_mant` carries the leading one at bit 65, fraction bits at 64..42, the round bit at 41 and lower bits at 40..0. For class 1 the biased exponent is `in_exp`+127. In round-to-nearest-even (mode 0), an exact tie rounds to an even fraction.
- R5: Rounding modes are 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. Modes 2 and 3 round the magnitude up only for a positive or a negative value respectively.
- R6: A biased exponent of 0 or less gives exponent field 0. The significand, including its leading one, is shifted right by 1 minus the biased exponent before rounding. Underflow is raised when that result is inexact or when `uf_trap_en` is high.
- R7: If rounding a denormalised value carries out of the 23-bit fraction, the result is the smallest normal number (exponent 1, fraction 0) and underflow is not raised.
- R8: If rounding a normal significand reaches 2.0, the exponent goes up by one and the fraction is 0. This carry can itself cause overflow.
- R9: A biased exponent of 255 or more after rounding raises overflow and inexact. The result is infinity in mode 0, in mode 2 for a positive value and in mode 3 for a negative value. Otherwise it is the largest finite number (exponent 254, fraction all ones).
- R10: Inexact is raised when any discarded bit is set, including `in_sticky`. `in_sticky` also takes part in the rounding decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | SIG_W+2 | Significand with leading one at the top, then round/extra bits |
| in_sticky | input | 1 | OR of bits already discarded upstream |
| rnd_mode | input | 2 | Rounding direction |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed result is present |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Result differs from the exact value |
| out_underflow | output | 1 | Tiny result, inexact or trapped |
| out_overflow | output | 1 | Result exceeded the finite range |

## Verification
The checker holds the following on every cycle:
- the one-cycle valid latency;
- that overflow always comes with inexact and produces only infinity or the largest finite magnitude;
- that underflow appears only with a zero exponent field, and only with inexact unless the trap was enabled;
- that special classes never raise a flag and that NaN keeps its all-ones exponent and quiet bit.

The exact rounded values can only be shown by the bench's chosen scenarios. These include:
- ties to even;
- the direction-dependent round-ups;
- the carry of a normal significand into the next binade;
- the denormal that rounds back into the smallest normal;
- the choice between infinity and the largest finite value.

// File: rtl/spk_pkg.sv
// Shared constants and types for the single-precision packer.
// Assumes the IEEE-754 binary32 layout: 1 sign, 8 exponent, 23 fraction bits.
package spk_pkg;
    localparam int FRAC_W  = 23;
    localparam int EXPF_W  = 8;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = 255;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
    } flags_t;
endpackage

// File: rtl/spk_align.sv
// Bias the exponent and align the significand to the 24-bit result grid.
// Normal values keep 24 bits. Values with a biased exponent <= 0 are shifted
// further right by (1 - biased). Bits shifted below the round bit fold into sticky.
// Assumes the leading one of mant_i sits in its top bit.
module spk_align
    import spk_pkg::*;
#(
    parameter int SIG_W = 64,
    parameter int EXP_W = 16
) (
    input  logic [SIG_W+1:0]           mant_i,
    input  logic                       sticky_i,
    input  logic signed [EXP_W-1:0]    exp_i,
    output logic signed [EXP_W+1:0]    biased_o,
    output logic                       sub_o,
    output logic [FRAC_W:0]            kept_o,
    output logic                       rbit_o,
    output logic                       sticky_o
);
    localparam int IN_W = SIG_W + 2;
    localparam int BW   = EXP_W + 2;
    localparam int BASE = IN_W - FRAC_W - 2;
    localparam int CAP  = IN_W + 1 - BASE;
    localparam int SHW  = $clog2(IN_W + 2) + 1;
    localparam logic signed [BW-1:0] BIAS_S = BW'(BIAS);
    localparam logic signed [BW-1:0] ONE_S  = BW'(1);
    localparam logic signed [BW-1:0] CAP_S  = BW'(CAP);

    logic signed [BW-1:0] sub_sh;
    logic signed [BW-1:0] sh_clamped;
    logic [SHW-1:0]       amt;
    logic [IN_W-1:0]      lost_mask;
    logic [FRAC_W+1:0]    low;

    // Bias the exponent and pick the normal or denormalising path.
    always_comb begin
        biased_o = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + BIAS_S;
        sub_o    = (biased_o <= 0);
    end

    // Shift distance: a fixed base, plus the clamped extra shift for tiny values.
    always_comb begin
        sub_sh     = ONE_S - biased_o;
        sh_clamped = (sub_sh > CAP_S) ? CAP_S : sub_sh;
        amt        = sub_o ? (SHW'(BASE) + SHW'(sh_clamped)) : SHW'(BASE);
    end

    // Extract the kept bits and the round bit, and OR the rest into sticky.
    always_comb begin
        low       = (FRAC_W+2)'(mant_i >> amt);
        lost_mask = ~({IN_W{1'b1}} << amt);
        kept_o    = low[FRAC_W+1:1];
        rbit_o    = low[0];
        sticky_o  = (|(mant_i & lost_mask)) | sticky_i;
    end
endmodule

// File: rtl/spk_round.sv
// Decide the round-up increment for the selected direction and apply it.
// sum_o has one extra bit so that a carry out of the kept field is visible.
module spk_round
    import spk_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic              sign_i,
    input  logic [FRAC_W:0]   kept_i,
    input  logic              rbit_i,
    input  logic              sticky_i,
    output logic [FRAC_W+1:0] sum_o,
    output logic              inexact_o
);
    logic incr;

    // Increment decision per rounding direction.
    always_comb begin
        inexact_o = rbit_i | sticky_i;
        unique case (rmode_e'(mode_i))
            RM_NEAR_EVEN: incr = rbit_i & (sticky_i | kept_i[0]);
            RM_ZERO:      incr = 1'b0;
            RM_UP:        incr = inexact_o & ~sign_i;
            RM_DOWN:      incr = inexact_o & sign_i;
            default:      incr = 1'b0;
        endcase
    end

    // Add the increment with carry into the extra top bit.
    always_comb sum_o = {1'b0, kept_i} + (FRAC_W+2)'(incr);
endmodule

// File: rtl/spk_compose.sv
// Assemble the packed word and its flags from the class and the rounded fields.
// Special classes bypass rounding. Normal carries bump the exponent.
// Tiny values either stay denormal or reach the smallest normal.
// Overflow saturates to infinity or to the largest finite value.
module spk_compose
    import spk_pkg::*;
#(
    parameter int EXP_W = 16
) (
    input  logic [1:0]              cls_i,
    input  logic                    sign_i,
    input  logic signed [EXP_W+1:0] biased_i,
    input  logic                    sub_i,
    input  logic [FRAC_W+1:0]       sum_i,
    input  logic                    inexact_i,
    input  logic [FRAC_W-2:0]       nan_frac_i,
    input  logic [1:0]              mode_i,
    input  logic                    trap_i,
    output logic [31:0]             word_o,
    output flags_t                  flags_o
);
    localparam int BW = EXP_W + 2;
    localparam logic signed [BW-1:0] TOP_S = BW'(EXP_TOP);
    localparam logic [EXPF_W-1:0] EXP_ONES = '1;
    localparam logic [EXPF_W-1:0] EXP_MAXF = EXP_ONES - 1'b1;

    logic signed [BW-1:0] exp_r;
    logic                 to_inf;

    // Exponent after a possible carry out of a normal significand.
    always_comb exp_r = biased_i + $signed({{(BW-1){1'b0}}, sum_i[FRAC_W+1]});

    // Overflow destination chosen by rounding direction and sign.
    always_comb begin
        unique case (rmode_e'(mode_i))
            RM_NEAR_EVEN: to_inf = 1'b1;
            RM_ZERO:      to_inf = 1'b0;
            RM_UP:        to_inf = ~sign_i;
            RM_DOWN:      to_inf = sign_i;
            default:      to_inf = 1'b1;
        endcase
    end

    // Select the packed result and the flags for this class and range.
    always_comb begin
        word_o  = {sign_i, 31'd0};
        flags_o = '0;
        unique case (cls_e'(cls_i))
            CLS_ZERO: word_o = {sign_i, 31'd0};
            CLS_INF:  word_o = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
            CLS_NAN:  word_o = {sign_i, EXP_ONES, 1'b1, nan_frac_i};
            CLS_NUM: begin
                flags_o.inexact = inexact_i;
                if (sub_i) begin
                    if (sum_i[FRAC_W]) begin
                        word_o = {sign_i, EXPF_W'(1), {FRAC_W{1'b0}}};
                    end else begin
                        word_o = {sign_i, {EXPF_W{1'b0}}, sum_i[FRAC_W-1:0]};
                        flags_o.underflow = inexact_i | trap_i;
                    end
                end else if (exp_r >= TOP_S) begin
                    flags_o.overflow = 1'b1;
                    flags_o.inexact  = 1'b1;
                    word_o = to_inf ? {sign_i, EXP_ONES, {FRAC_W{1'b0}}}
                                    : {sign_i, EXP_MAXF, {FRAC_W{1'b1}}};
                end else begin
                    word_o = {sign_i, exp_r[EXPF_W-1:0], sum_i[FRAC_W-1:0]};
                end
            end
            default: word_o = {sign_i, 31'd0};
        endcase
    end
endmodule

// File: rtl/fp_sgl_packer.sv
// Top of the single-precision packer: align, round, compose, then one register stage.
// Assumes in_mant is normalised (leading one at its top bit) whenever in_class is a number.
module fp_sgl_packer
    import spk_pkg::*;
#(
    parameter int SIG_W = 64,
    parameter int EXP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [SIG_W+1:0]        in_mant,
    input  logic                    in_sticky,
    input  logic [1:0]              rnd_mode,
    input  logic                    uf_trap_en,
    output logic                    out_valid,
    output logic [31:0]             out_word,
    output logic                    out_inexact,
    output logic                    out_underflow,
    output logic                    out_overflow
);
    localparam int IN_W = SIG_W + 2;

    logic signed [EXP_W+1:0] biased;
    logic                    is_sub;
    logic [FRAC_W:0]         kept;
    logic                    rbit;
    logic                    sticky;
    logic [FRAC_W+1:0]       sum;
    logic                    inexact;
    logic [31:0]             word_c;
    flags_t                  flags_c;

    spk_align #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_align (
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .exp_i    (in_exp),
        .biased_o (biased),
        .sub_o    (is_sub),
        .kept_o   (kept),
        .rbit_o   (rbit),
        .sticky_o (sticky)
    );

    spk_round u_round (
        .mode_i    (rnd_mode),
        .sign_i    (in_sign),
        .kept_i    (kept),
        .rbit_i    (rbit),
        .sticky_i  (sticky),
        .sum_o     (sum),
        .inexact_o (inexact)
    );

    spk_compose #(.EXP_W(EXP_W)) u_compose (
        .cls_i      (in_class),
        .sign_i     (in_sign),
        .biased_i   (biased),
        .sub_i      (is_sub),
        .sum_i      (sum),
        .inexact_i  (inexact),
        .nan_frac_i (in_mant[IN_W-3 -: FRAC_W-1]),
        .mode_i     (rnd_mode),
        .trap_i     (uf_trap_en),
        .word_o     (word_c),
        .flags_o    (flags_c)
    );

    // Output register: capture the result on a valid input; valid follows by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_word      <= '0;
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word      <= word_c;
                out_inexact   <= flags_c.inexact;
                out_underflow <= flags_c.underflow;
                out_overflow  <= flags_c.overflow;
            end
        end
    end
endmodule

// File: rtl/fp_sgl_packer_chk.sv
// Property checker for fp_sgl_packer, attached with bind. Observes ports only.
module fp_sgl_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_class,
    input logic        uf_trap_en,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_inexact,
    input logic        out_underflow,
    input logic        out_overflow
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_NAN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd3) |=> (out_word[30:22] == 9'h1FF)); // R2
    AST_SPECIAL_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class != 2'd1) |=> !(out_inexact || out_underflow || out_overflow)); // R3
    AST_UF_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_word[30:23] == 8'd0)); // R6
    AST_UF_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !uf_trap_en) |=> (!out_underflow || out_inexact)); // R6
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> out_inexact); // R9
    AST_OVF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |->
        (out_word[30:0] == 31'h7F80_0000 || out_word[30:0] == 31'h7F7F_FFFF)); // R9
endmodule

bind fp_sgl_packer fp_sgl_packer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_class      (in_class),
    .uf_trap_en    (uf_trap_en),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .out_inexact   (out_inexact),
    .out_underflow (out_underflow),
    .out_overflow  (out_overflow)
);

// File: tb/test_fp_sgl_packer.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues hand-derived expectations, the monitor compares results.
module test_fp_sgl_packer;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_class = '0;
    logic               in_sign = 1'b0;
    logic signed [15:0] in_exp = '0;
    logic [65:0]        in_mant = '0;
    logic               in_sticky = 1'b0;
    logic [1:0]         rnd_mode = '0;
    logic               uf_trap_en = 1'b0;
    logic               out_valid;
    logic [31:0]        out_word;
    logic               out_inexact, out_underflow, out_overflow;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic [2:0]  flg;   // {inexact, underflow, overflow}
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fp_sgl_packer i_fp_sgl_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
        .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en), .out_valid(out_valid),
        .out_word(out_word), .out_inexact(out_inexact),
        .out_underflow(out_underflow), .out_overflow(out_overflow)
    );

    function automatic logic [65:0] mk(input logic [22:0] f, input logic g, input logic [40:0] r);
        return {1'b1, f, g, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic s, input logic signed [15:0] e,
                         input logic [65:0] m, input logic st, input logic [1:0] md,
                         input logic tr, input logic [31:0] w, input logic [2:0] f,
                         input string tag);
        exp_t x;
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = e; in_mant = m;
        in_sticky = st; rnd_mode = md; uf_trap_en = tr;
        x.word = w; x.flg = f; x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: pop one expectation for every valid result and compare word and flags.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", out_word, 32'h0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(out_word == x.word, {x.tag, " word"}, out_word, x.word);
                check({out_inexact, out_underflow, out_overflow} == x.flg, {x.tag, " flags"},
                      {29'd0, out_inexact, out_underflow, out_overflow}, {29'd0, x.flg});
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_word == 32'h0 &&
              {out_inexact, out_underflow, out_overflow} == 3'b000,
              "R1 reset state", {31'd0, out_valid}, 32'h0);

        // Special classes (R2, R3): rounding inputs must not matter
        apply(2'd0, 1'b1, 16'sd5, mk(23'h1, 1'b1, 41'h1), 1'b1, 2'd3, 1'b1, 32'h8000_0000, 3'b000, "R3 zero");
        apply(2'd2, 1'b0, 16'sd0, mk(23'h0, 1'b0, 41'h0), 1'b1, 2'd2, 1'b0, 32'h7F80_0000, 3'b000, "R3 inf pos");
        apply(2'd2, 1'b1, 16'sd0, mk(23'h0, 1'b1, 41'h0), 1'b0, 2'd3, 1'b0, 32'hFF80_0000, 3'b000, "R3 inf neg");
        apply(2'd3, 1'b1, 16'sd0, mk(23'h012345, 1'b1, 41'h5), 1'b1, 2'd2, 1'b1, 32'hFFC1_2345, 3'b000, "R2 nan quiet");
        // Normal values and ties (R4)
        apply(2'd1, 1'b0, 16'sd0, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 3'b000, "R4 one");
        apply(2'd1, 1'b0, 16'sd1, mk(23'h400000, 1'b0, 41'h0), 1'b0, 2'd0, 1'b0, 32'h4040_0000, 3'b000, "R4 three");
        apply(2'd1, 1'b0, 16'sd0, mk(23'h0, 1'b1, 41'h0), 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 3'b100, "R4 tie even stays");
        apply(2'd1, 1'b0, 16'sd0, mk(23'h1, 1'b1, 41'h0), 1'b0, 2'd0, 1'b0, 32'h3F80_0002, 3'b100, "R4 tie odd up");
        // Directed modes (R5)
        apply(2'd1, 1'b0, 16'sd0, mk(23'h1, 1'b1, 41'h1), 1'b0, 2'd1, 1'b0, 32'h3F80_0001, 3'b100, "R5 toward zero");
        apply(2'd1, 1'b0, 16'sd0, mk(23'h1, 1'b0, 41'h1), 1'b0, 2'd2, 1'b0, 32'h3F80_0002, 3'b100, "R5 up positive");
        apply(2'd1, 1'b1, 16'sd0, mk(23'h1, 1'b0, 41'h1), 1'b0, 2'd2, 1'b0, 32'hBF80_0001, 3'b100, "R5 up negative");
        apply(2'd1, 1'b1, 16'sd0, mk(23'h1, 1'b0, 41'h1), 1'b0, 2'd3, 1'b0, 32'hBF80_0002, 3'b100, "R5 down negative");
        // Upstream sticky alone (R10)
        apply(2'd1, 1'b0, 16'sd0, mk(23'h0, 1'b0, 41'h0), 1'b1, 2'd2, 1'b0, 32'h3F80_0001, 3'b100, "R10 sticky input");
        apply(2'd1, 1'b0, 16'sd0, mk(23'h0, 1'b0, 41'h0), 1'b1, 2'd1, 1'b0, 32'h3F80_0000, 3'b100, "R10 sticky truncated");
        // Carry to next binade (R8)
        apply(2'd1, 1'b0, 16'sd0, mk(23'h7FFFFF, 1'b1, 41'h0), 1'b0, 2'd0, 1'b0, 32'h4000_0000, 3'b100, "R8 carry 2.0");
        apply(2'd1, 1'b0, 16'sd127, mk(23'h7FFFFF, 1'b1, 41'h0), 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 3'b101, "R8 carry overflow");
        // Overflow (R9)
        apply(2'd1, 1'b0, 16'sd128, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 3'b101, "R9 nearest inf");
        apply(2'd1, 1'b1, 16'sd200, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd1, 1'b0, 32'hFF7F_FFFF, 3'b101, "R9 zero max");
        apply(2'd1, 1'b1, 16'sd200, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd2, 1'b0, 32'hFF7F_FFFF, 3'b101, "R9 up negative max");
        apply(2'd1, 1'b1, 16'sd200, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd3, 1'b0, 32'hFF80_0000, 3'b101, "R9 down negative inf");
        apply(2'd1, 1'b0, 16'sd127, mk(23'h7FFFFF, 1'b0, 41'h0), 1'b0, 2'd0, 1'b0, 32'h7F7F_FFFF, 3'b000, "R9 largest exact");
        // Tiny values (R6, R7)
        apply(2'd1, 1'b0, -16'sd127, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd0, 1'b0, 32'h0040_0000, 3'b000, "R6 exact no trap");
        apply(2'd1, 1'b0, -16'sd127, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd0, 1'b1, 32'h0040_0000, 3'b010, "R6 exact trapped");
        apply(2'd1, 1'b0, -16'sd130, mk(23'h0, 1'b0, 41'h1), 1'b0, 2'd0, 1'b0, 32'h0008_0000, 3'b110, "R6 inexact");
        apply(2'd1, 1'b0, -16'sd200, mk(23'h0, 1'b0, 41'h0), 1'b0, 2'd2, 1'b0, 32'h0000_0001, 3'b110, "R6 far tiny up");
        apply(2'd1, 1'b1, -16'sd127, mk(23'h7FFFFF, 1'b0, 41'h0), 1'b0, 2'd0, 1'b1, 32'h8080_0000, 3'b100, "R7 to min normal");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid drops", {31'd0, out_valid}, 32'h0);
        check(sb.size() == 0, "R1 all results seen", sb.size(), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule